// File: doc/BRIEF.md
# Two-Button Sequence Lock

This block is a one-hot state machine for a combination lock that runs from a slow clock of about 10 Hz. There are two button inputs: one for a "1" digit and one for a "0" digit. The lock opens on the digit sequence 1, 0, 1, 1.

Each digit is entered with a press and then a release. Every digit has a "pressed" state, held for as long as its button stays down, and a "released" state, so a long press counts as only one digit. A wrong digit sends the machine through a one-cycle error state back to the idle state, and the search starts again from the first digit. Overlapping matches are never taken.

When the whole code has been entered, the machine spends one cycle in a done state. It then enters an open state and stays there until an internal counter reaches its terminal count. The output is the one-hot state vector itself.

Top module: `seq_lock`

## Requirements
- R1: A synchronous active-high reset puts the state vector at 0x001 (idle) on the next clock edge.
- R2: Exactly one bit of the 11-bit state vector is high at every clock. The bit order is: bit0 idle, bit1 one-pressed, bit2 got-1, bit3 zero-pressed, bit4 got-10, bit5 one-pressed, bit6 got-101, bit7 one-pressed, bit8 got-1011 (done), bit9 open, bit10 error.
- R3: In idle, only the one button alone (one=1, zero=0) moves the machine to 0x002. The inputs 00, 01 and 11 leave it in idle.
- R4: In a pressed state, the machine stays for as long as that digit's button is held. Releasing the button moves it to the matching released state, so a long press counts as one digit.
- R5: In got-1 (0x004), the zero button alone moves the machine to 0x008, no press holds it, and any input with one=1 moves it to error (0x400).
- R6: In got-10 (0x010) and got-101 (0x040), the one button alone moves the machine to the next pressed state, no press holds it, and any input with zero=1 moves it to error.
- R7: Error lasts one cycle and then returns to idle whatever the inputs are. The input 1 0 1 0 1 1 does not open the lock.
- R8: Done (0x100) lasts exactly one cycle and is followed by open (0x200).
- R9: Open lasts exactly 16 cycles, set by a 4-bit counter that is cleared outside open. The machine then returns to idle.
- R10: Button inputs have no effect while the machine is in open.
- R11: Pressing both buttons together never advances the sequence and never opens the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow state clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_one | input | 1 | High while the "1" button is held |
| btn_zero | input | 1 | High while the "0" button is held |
| state_vec | output | 11 (2*CODE_LEN+3) | One-hot current state |

## Verification
Two events can fall in the same clock:

- **Counter expiry and a new press.** On the last open cycle, the counter expires while a new "1" press is already held. The bench drives the one button during that final cycle. It expects idle first, with the button ignored, and then the pressed state one cycle later, because the button is still held.
- **Error recovery and a held input.** While in error, the bench holds a wrong press. It expects idle on the next cycle regardless of that input.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int DEF_CODE_LEN = 4;
    localparam int DEF_TIMER_W  = 4;

    function automatic int idle_idx();
        return 0;
    endfunction

    function automatic int press_idx(input int digit);
        return 2 * digit + 1;
    endfunction

    function automatic int rel_idx(input int digit);
        return 2 * digit + 2;
    endfunction

    function automatic int open_idx(input int len);
        return 2 * len + 1;
    endfunction

    function automatic int err_idx(input int len);
        return 2 * len + 2;
    endfunction

    function automatic int num_states(input int len);
        return 2 * len + 3;
    endfunction

endpackage

// File: rtl/lock_timer.sv
module lock_timer #(
    parameter int TIMER_W = lock_pkg::DEF_TIMER_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [TIMER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (&cnt_q);

    // R9: counter is held clear whenever the open state is not active
    a_r9_timer_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

    // R9: an expiry wraps the counter back to zero
    a_r9_timer_wrap: assert property (@(posedge clk) disable iff (rst)
        expired |=> (cnt_q == '0));
endmodule

// File: rtl/lock_next.sv
module lock_next #(
    parameter int                    CODE_LEN = lock_pkg::DEF_CODE_LEN,
    parameter logic [CODE_LEN-1:0]   CODE     = 4'b1011,
    localparam int                   NS       = lock_pkg::num_states(CODE_LEN)
) (
    input  logic [NS-1:0] cur,
    input  logic          one,
    input  logic          zero,
    input  logic          expired,
    output logic [NS-1:0] nxt
);
    import lock_pkg::*;

    localparam int OPEN = open_idx(CODE_LEN);
    localparam int ERR  = err_idx(CODE_LEN);

    // code digits padded with a dummy trailing bit so every lookahead index is legal
    localparam logic [CODE_LEN:0] CODE_EXT = {CODE, 1'b0};

    logic only_one, only_zero;
    assign only_one  = one && !zero;
    assign only_zero = zero && !one;

    always_comb begin
        nxt = '0;

        // idle: wait for the first digit pressed alone
        if (cur[idle_idx()]) begin
            if (CODE_EXT[CODE_LEN] ? only_one : only_zero) nxt[press_idx(0)] = 1'b1;
            else                                           nxt[idle_idx()]   = 1'b1;
        end

        for (int i = 0; i < CODE_LEN; i++) begin
            // pressed state: hold until this digit's button is released
            if (cur[press_idx(i)]) begin
                if (CODE_EXT[CODE_LEN-i] ? one : zero) nxt[press_idx(i)] = 1'b1;
                else                                   nxt[rel_idx(i)]   = 1'b1;
            end
            // released state: look for the following digit
            if (cur[rel_idx(i)]) begin
                if (i == CODE_LEN - 1) begin
                    nxt[OPEN] = 1'b1;
                end else if (CODE_EXT[CODE_LEN-1-i] ? only_one : only_zero) begin
                    nxt[press_idx(i+1)] = 1'b1;
                end else if (CODE_EXT[CODE_LEN-1-i] ? zero : one) begin
                    nxt[ERR] = 1'b1;
                end else begin
                    nxt[rel_idx(i)] = 1'b1;
                end
            end
        end

        // open: buttons ignored, leave on timer expiry
        if (cur[OPEN]) begin
            if (expired) nxt[idle_idx()] = 1'b1;
            else         nxt[OPEN]       = 1'b1;
        end

        // error: one cycle, then restart
        if (cur[ERR]) nxt[idle_idx()] = 1'b1;
    end
endmodule

// File: rtl/seq_lock.sv
module seq_lock #(
    parameter int                  CODE_LEN = lock_pkg::DEF_CODE_LEN,
    parameter logic [CODE_LEN-1:0] CODE     = 4'b1011,
    parameter int                  TIMER_W  = lock_pkg::DEF_TIMER_W,
    localparam int                 NS       = lock_pkg::num_states(CODE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          btn_one,
    input  logic          btn_zero,
    output logic [NS-1:0] state_vec
);
    import lock_pkg::*;

    localparam int OPEN = open_idx(CODE_LEN);
    localparam int ERR  = err_idx(CODE_LEN);
    localparam int DONE = rel_idx(CODE_LEN - 1);

    logic [NS-1:0] state_q, state_d;
    logic          tmo;

    lock_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q[OPEN]),
        .expired (tmo)
    );

    lock_next #(.CODE_LEN(CODE_LEN), .CODE(CODE)) u_next (
        .cur     (state_q),
        .one     (btn_one),
        .zero    (btn_zero),
        .expired (tmo),
        .nxt     (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= NS'(1);
        else     state_q <= state_d;
    end

    assign state_vec = state_q;

    // R2: one-hot at every clock
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_q));

    // R3: idle is left only on the first digit pressed alone
    a_r3_idle_filter: assert property (@(posedge clk) disable iff (rst)
        (state_q[0] && !(btn_one && !btn_zero)) |=> state_q[0]);

    // R7: error always returns to idle
    a_r7_err_to_idle: assert property (@(posedge clk) disable iff (rst)
        state_q[ERR] |=> state_q[0]);

    // R8: done lasts one cycle, then open
    a_r8_done_to_open: assert property (@(posedge clk) disable iff (rst)
        state_q[DONE] |=> state_q[OPEN]);

    // R10: open holds regardless of buttons until expiry
    a_r10_open_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q[OPEN] && !tmo) |=> state_q[OPEN]);

    // R9: expiry ends the open period
    a_r9_open_exit: assert property (@(posedge clk) disable iff (rst)
        tmo |=> state_q[0]);
endmodule

// File: tb/sim_seq_lock.sv
module sim_seq_lock;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        u   = 1'b0;
    logic        z   = 1'b0;
    logic [10:0] st;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    localparam logic [10:0] S_IDLE = 11'h001, S_P1 = 11'h002, S_G1 = 11'h004,
                            S_P10 = 11'h008, S_G10 = 11'h010, S_P101 = 11'h020,
                            S_G101 = 11'h040, S_P1011 = 11'h080, S_DONE = 11'h100,
                            S_OPEN = 11'h200, S_ERR = 11'h400;

    always #4 clk = ~clk;

    seq_lock u0 (.clk(clk), .rst(rst), .btn_one(u), .btn_zero(z), .state_vec(st));

    task automatic chk(input logic [10:0] exp, input string tag);
        n_chk++;
        if (st !== exp) begin
            n_fail++;
            $display("FAIL %s: state=%03h expected=%03h", tag, st, exp);
        end
    endtask

    // drive buttons at a falling edge, return at the next falling edge
    task automatic step(input logic bu, input logic bz);
        u = bu; z = bz;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; u = 1'b0; z = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(S_IDLE, "R1 reset idle");
        n_chk++;
        if ($countones(st) != 1) begin
            n_fail++;
            $display("FAIL R2 onehot: state=%03h expected=one bit", st);
        end
    endtask

    task automatic t_idle_filter();
        do_reset();
        step(0, 1); chk(S_IDLE, "R3 zero in idle");
        step(1, 1); chk(S_IDLE, "R3 R11 both in idle");
        step(0, 0); chk(S_IDLE, "R3 none in idle");
        step(1, 0); chk(S_P1, "R3 one in idle");
    endtask

    task automatic t_long_press();
        do_reset();
        for (int k = 0; k < 6; k++) step(1, 0);
        chk(S_P1, "R4 long one press held");
        step(1, 1); chk(S_P1, "R4 one held with zero");
        step(0, 0); chk(S_G1, "R4 release one");
        step(0, 0); chk(S_G1, "R5 got1 hold");
        for (int k = 0; k < 5; k++) step(0, 1);
        chk(S_P10, "R4 long zero press held");
        step(0, 0); chk(S_G10, "R4 release zero");
    endtask

    task automatic t_g1_paths();
        do_reset();
        step(1, 0); step(0, 0);
        step(1, 0); chk(S_ERR, "R5 one in got1");
        do_reset();
        step(1, 0); step(0, 0);
        step(1, 1); chk(S_ERR, "R5 R11 both in got1");
    endtask

    task automatic t_g10_paths();
        do_reset();
        step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        step(0, 0); chk(S_G10, "R6 got10 hold");
        step(1, 1); chk(S_ERR, "R6 R11 both in got10");
        do_reset();
        step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        step(1, 0); chk(S_P101, "R6 got10 advance");
        step(0, 0); chk(S_G101, "R6 release to got101");
        step(0, 1); chk(S_ERR, "R6 zero in got101");
    endtask

    task automatic t_restart();
        do_reset();
        step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        step(1, 0); step(0, 0);
        step(0, 1); chk(S_ERR, "R7 wrong fourth digit");
        step(0, 1); chk(S_IDLE, "R7 error to idle with press held");
        step(0, 0);
        step(1, 0); step(0, 0); chk(S_G1, "R7 restarted at first digit");
        step(1, 0); chk(S_ERR, "R7 101011 rejected");
        step(0, 0); chk(S_IDLE, "R7 back to idle");
    endtask

    task automatic t_both_spam();
        bit opened = 1'b0;
        do_reset();
        for (int k = 0; k < 24; k++) begin
            step(1, 1);
            if (st == S_OPEN || st == S_DONE) opened = 1'b1;
            step(0, 0);
            if (st == S_OPEN || st == S_DONE) opened = 1'b1;
        end
        n_chk++;
        if (opened) begin
            n_fail++;
            $display("FAIL R11 both spam: opened=1 expected=0");
        end
        chk(S_IDLE, "R11 still idle");
    endtask

    task automatic t_open();
        do_reset();
        step(1, 0); step(1, 0); step(0, 0);
        step(0, 1); step(0, 0);
        step(1, 0); step(0, 0);
        step(1, 0); chk(S_P1011, "R4 last press");
        step(1, 0); chk(S_P1011, "R4 last press held");
        step(0, 0); chk(S_DONE, "R8 done");
        step(1, 1); chk(S_OPEN, "R8 open after one done cycle");
        // 15 more open cycles with buttons toggling
        for (int k = 0; k < 14; k++) begin
            step(k[0], k[1]);
            if (st !== S_OPEN) begin
                n_chk++; n_fail++;
                $display("FAIL R10 open held: state=%03h expected=%03h", st, S_OPEN);
            end
        end
        step(1, 0); chk(S_OPEN, "R9 R10 sixteenth open cycle");
        step(1, 0); chk(S_IDLE, "R9 exit after 16 cycles");
        step(1, 0); chk(S_P1, "R9 press held at expiry then counted");
        step(0, 0); chk(S_G1, "R4 release after reopen");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_filter();
        t_long_press();
        t_g1_paths();
        t_g10_paths();
        t_restart();
        t_both_spam();
        t_open();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all R): finished=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule